// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between one narrow port (A) and two wide-side halves (1B and 2B), all three `WORD_W` bits wide (12 by default). Going from A to B, two narrow words that arrive one after the other leave together as one double-width word. The first word goes out on 1B and the second on 2B. Going from B to A, each B half has its own capture register, and a registered select picks which of the two drives A.

All storage loads on the rising clock edge, and each register has its own active-low load enable. The 1B-bound path has two stages, and both advance only on edges where its load enable is low. The 2B-bound path has a single register. The usual sequence is: load word X on the 1B path, then word Y on the 2B path, then the next word on the 1B path. After that third edge, 1B shows X and 2B shows Y. The port select and the two active-low output enables are registered, so any change of bus direction takes effect on a clock edge. Each tri-state port is modelled as an input bus, an output bus and an active-high drive flag.

Top module: `wide_bus_xchg`

## Requirements
- R1: While `rst_n` is low at a rising edge, every data register is cleared to zero, the registered select picks the 1B capture register, and both drive flags go low (undriven).
- R2: `b1_out` is the second stage of a two-stage pipe fed from `a_in`. On an edge where `ld_a1_n` is low, stage one takes `a_in` and stage two takes the old stage one. A word therefore reaches `b1_out` after two such edges.
- R3: On an edge where `ld_a2_n` is low, `a_in` is stored and shows on `b2_out` right after that edge.
- R4: Load word X with `ld_a1_n` low, then word Y with `ld_a2_n` low, then any word with `ld_a1_n` low. After the third edge, `b1_out` equals X and `b2_out` equals Y.
- R5: On an edge where `ld_b1_n` (or `ld_b2_n`) is low, the 1B (or 2B) capture register takes `b1_in` (or `b2_in`). While the enable is high, the register keeps its value, whatever its input does.
- R6: `sel_b1` is registered on each edge. A registered 1 puts the 1B capture register on `a_out`, and a registered 0 puts the 2B capture register there.
- R7: `a_drive` equals the inverse of `oe_a_n` as sampled on the previous edge.
- R8: `b_drive` equals the inverse of `oe_b_n` as sampled on the previous edge. It applies to 1B and 2B together, and it may be high at the same time as `a_drive`.
- R9: If an output's register enable is high at an edge, that output is unchanged after the edge. For `b1_out` this applies even when `ld_a2_n` loads the 2B register on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | WORD_W | Narrow port data arriving |
| a_out | output | WORD_W | Narrow port data leaving |
| a_drive | output | 1 | High when the narrow port is driven |
| b1_in | input | WORD_W | First wide half, data arriving |
| b1_out | output | WORD_W | First wide half, data leaving |
| b2_in | input | WORD_W | Second wide half, data arriving |
| b2_out | output | WORD_W | Second wide half, data leaving |
| b_drive | output | 1 | High when both wide halves are driven |
| ld_a1_n | input | 1 | Active-low load for the 1B-bound pipe |
| ld_a2_n | input | 1 | Active-low load for the 2B-bound register |
| ld_b1_n | input | 1 | Active-low load for the 1B capture register |
| ld_b2_n | input | 1 | Active-low load for the 2B capture register |
| sel_b1 | input | 1 | Source select for A, registered (1 = 1B) |
| oe_a_n | input | 1 | Active-low A output enable, registered |
| oe_b_n | input | 1 | Active-low B output enable, registered |

## Verification
The select register and a capture-register load can land on the same edge. In that case `a_out` must show the newly captured word from the newly selected half, so the select and the load must both take effect on that edge. A load of the 2B-bound register can also coincide with a hold of the 1B pipe, and then only `b2_out` may move. Random stimulus toggles all four load enables and the select on the same edges, and a cycle-accurate bench model judges every output after every edge. Directed sequences then check the word-pair alignment and the drive flags with both sides enabled together.

// File: rtl/xchg_pkg.sv
// Shared types for the bus exchanger.
// Assumes: nothing beyond IEEE 1800-2017.
package xchg_pkg;
    // Registered direction and select controls.
    typedef struct packed {
        logic sel_b1;   // 1: A shows the 1B capture register
        logic oe_a_n;   // active-low A enable
        logic oe_b_n;   // active-low B enable
    } xchg_ctrl_t;

    // Control value after reset: 1B selected, both sides undriven.
    localparam xchg_ctrl_t CTRL_RESET = '{sel_b1: 1'b1, oe_a_n: 1'b1, oe_b_n: 1'b1};
endpackage

// File: rtl/xchg_a2b_path.sv
// A-to-B direction: two-stage pipe toward 1B and one register toward 2B.
// Assumes: synchronous active-low reset. Both pipe stages advance only
// when ld_a1_n is low, so a word loaded there pairs with the next 2B load.
module xchg_a2b_path #(
    parameter int WORD_W = 12,
    parameter int PIPE_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] a_in,
    input  logic              ld_a1_n,
    input  logic              ld_a2_n,
    output logic [WORD_W-1:0] b1_q,
    output logic [WORD_W-1:0] b2_q
);
    localparam int LAST = PIPE_STAGES - 1;

    logic [WORD_W-1:0] stage [PIPE_STAGES];

    // Purpose: each stage loads from its upstream neighbour on an enabled edge.
    for (genvar s = 0; s < PIPE_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage[s] <= '0;
            else if (!ld_a1_n)
                stage[s] <= (s == 0) ? a_in : stage[(s == 0) ? 0 : s-1];
        end
    end

    // Purpose: single register toward 2B.
    always_ff @(posedge clk) begin
        if (!rst_n)
            b2_q <= '0;
        else if (!ld_a2_n)
            b2_q <= a_in;
    end

    assign b1_q = stage[LAST];
endmodule

// File: rtl/xchg_b2a_path.sv
// B-to-A direction: one capture register per B half and a select mux.
// Assumes: synchronous active-low reset; sel_q comes from the control register.
module xchg_b2a_path #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] b1_in,
    input  logic [WORD_W-1:0] b2_in,
    input  logic              ld_b1_n,
    input  logic              ld_b2_n,
    input  logic              sel_q,
    output logic [WORD_W-1:0] a_q
);
    logic [WORD_W-1:0] cap1, cap2;

    // Purpose: capture the 1B half when its enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap1 <= '0;
        else if (!ld_b1_n)
            cap1 <= b1_in;
    end

    // Purpose: capture the 2B half when its enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap2 <= '0;
        else if (!ld_b2_n)
            cap2 <= b2_in;
    end

    // Purpose: route the chosen capture register toward A.
    always_comb a_q = sel_q ? cap1 : cap2;
endmodule

// File: rtl/xchg_ctrl_regs.sv
// Registers the select and both output enables so direction changes on a clock edge.
// Assumes: synchronous active-low reset to 1B selected and both sides undriven.
module xchg_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_b1,
    input  logic oe_a_n,
    input  logic oe_b_n,
    output logic sel_q,
    output logic a_drive,
    output logic b_drive
);
    import xchg_pkg::*;

    xchg_ctrl_t ctrl_q;

    // Purpose: sample the controls on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else
            ctrl_q <= '{sel_b1: sel_b1, oe_a_n: oe_a_n, oe_b_n: oe_b_n};
    end

    assign sel_q   = ctrl_q.sel_b1;
    assign a_drive = ~ctrl_q.oe_a_n;
    assign b_drive = ~ctrl_q.oe_b_n;
endmodule

// File: rtl/wide_bus_xchg.sv
// Top of the registered narrow-to-wide bus exchanger.
// Assumes: one clock; synchronous active-low reset; tri-state pins modelled
// as separate in/out buses plus an active-high drive flag per side.
module wide_bus_xchg #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] a_in,
    output logic [WORD_W-1:0] a_out,
    output logic              a_drive,
    input  logic [WORD_W-1:0] b1_in,
    output logic [WORD_W-1:0] b1_out,
    input  logic [WORD_W-1:0] b2_in,
    output logic [WORD_W-1:0] b2_out,
    output logic              b_drive,
    input  logic              ld_a1_n,
    input  logic              ld_a2_n,
    input  logic              ld_b1_n,
    input  logic              ld_b2_n,
    input  logic              sel_b1,
    input  logic              oe_a_n,
    input  logic              oe_b_n
);
    logic sel_q;

    xchg_ctrl_regs u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_b1(sel_b1), .oe_a_n(oe_a_n),
        .oe_b_n(oe_b_n), .sel_q(sel_q), .a_drive(a_drive), .b_drive(b_drive)
    );

    xchg_a2b_path #(.WORD_W(WORD_W), .PIPE_STAGES(2)) u_a2b (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .ld_a1_n(ld_a1_n),
        .ld_a2_n(ld_a2_n), .b1_q(b1_out), .b2_q(b2_out)
    );

    xchg_b2a_path #(.WORD_W(WORD_W)) u_b2a (
        .clk(clk), .rst_n(rst_n), .b1_in(b1_in), .b2_in(b2_in),
        .ld_b1_n(ld_b1_n), .ld_b2_n(ld_b2_n), .sel_q(sel_q), .a_q(a_out)
    );
endmodule

// File: rtl/wide_bus_xchg_chk.sv
// Port-level assertions for wide_bus_xchg, bound to every instance.
// Assumes: synchronous active-low reset.
module wide_bus_xchg_chk #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] a_in,
    input logic [WORD_W-1:0] a_out,
    input logic              a_drive,
    input logic [WORD_W-1:0] b1_in,
    input logic [WORD_W-1:0] b1_out,
    input logic [WORD_W-1:0] b2_in,
    input logic [WORD_W-1:0] b2_out,
    input logic              b_drive,
    input logic              ld_a1_n,
    input logic              ld_a2_n,
    input logic              ld_b1_n,
    input logic              ld_b2_n,
    input logic              sel_b1,
    input logic              oe_a_n,
    input logic              oe_b_n
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!a_drive && !b_drive && b1_out == '0 && b2_out == '0 && a_out == '0));

    // R3
    b2_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_a2_n |=> b2_out == $past(a_in));

    // R9
    b1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_a1_n |=> $stable(b1_out));

    // R9
    b2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_a2_n |=> $stable(b2_out));

    // R6
    sel_1b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b1 && !ld_b1_n) |=> a_out == $past(b1_in));

    // R6
    sel_2b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_b1 && !ld_b2_n) |=> a_out == $past(b2_in));

    // R7
    a_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> a_drive == !$past(oe_a_n));

    // R8
    b_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> b_drive == !$past(oe_b_n));
endmodule

bind wide_bus_xchg wide_bus_xchg_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/wide_bus_xchg_tb.sv
module wide_bus_xchg_tb;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         ld_a1_n = 1'b1, ld_a2_n = 1'b1, ld_b1_n = 1'b1, ld_b2_n = 1'b1;
    logic         sel_b1 = 1'b1, oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_drive, b_drive;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench reference model state
    logic [W-1:0] m_s1 = '0, m_s2 = '0, m_r2 = '0, m_c1 = '0, m_c2 = '0;
    logic         m_sel = 1'b1, m_oea = 1'b1, m_oeb = 1'b1;

    always #5 clk = ~clk;

    wide_bus_xchg #(.WORD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b1_in(b1_in), .b1_out(b1_out), .b2_in(b2_in), .b2_out(b2_out),
        .b_drive(b_drive), .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n),
        .ld_b1_n(ld_b1_n), .ld_b2_n(ld_b2_n), .sel_b1(sel_b1),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_a_out();
        return m_sel ? m_c1 : m_c2;
    endfunction

    // Apply inputs at the falling edge, let one rising edge pass, update the model, sample.
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b1, input logic [W-1:0] b2,
                        input logic [3:0] ld_n, input logic sel, input logic oea, input logic oeb);
        @(negedge clk);
        a_in = a; b1_in = b1; b2_in = b2;
        {ld_a1_n, ld_a2_n, ld_b1_n, ld_b2_n} = ld_n;
        sel_b1 = sel; oe_a_n = oea; oe_b_n = oeb;
        @(posedge clk);
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_r2 = '0; m_c1 = '0; m_c2 = '0;
            m_sel = 1'b1; m_oea = 1'b1; m_oeb = 1'b1;
        end else begin
            if (!ld_n[3]) begin m_s2 = m_s1; m_s1 = a; end
            if (!ld_n[2]) m_r2 = a;
            if (!ld_n[1]) m_c1 = b1;
            if (!ld_n[0]) m_c2 = b2;
            m_sel = sel; m_oea = oea; m_oeb = oeb;
        end
        #2;
    endtask

    task automatic compare_all();
        chk("R2 b1_out", 32'(b1_out), 32'(m_s2));
        chk("R3 b2_out", 32'(b2_out), 32'(m_r2));
        chk("R6 a_out", 32'(a_out), 32'(exp_a_out()));
        chk("R7 a_drive", 32'(a_drive), 32'(!m_oea));
        chk("R8 b_drive", 32'(b_drive), 32'(!m_oeb));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] wx, wy, hold1, hold2;
        void'($urandom(32'h5eed_0142));

        // R1: reset clears data, selects 1B, disables both drives
        step(12'hABC, 12'h123, 12'h456, 4'b0000, 1'b0, 1'b0, 1'b0);
        step(12'hABC, 12'h123, 12'h456, 4'b0000, 1'b0, 1'b0, 1'b0);
        chk("R1 b1_out", 32'(b1_out), 0);
        chk("R1 b2_out", 32'(b2_out), 0);
        chk("R1 a_out", 32'(a_out), 0);
        chk("R1 a_drive", 32'(a_drive), 0);
        chk("R1 b_drive", 32'(b_drive), 0);
        rst_n = 1'b1;

        // R8: both sides driven together
        step('0, '0, '0, 4'b1111, 1'b1, 1'b0, 1'b0);
        chk("R8 both drive a", 32'(a_drive), 1);
        chk("R8 both drive b", 32'(b_drive), 1);

        // R4: word pair alignment
        wx = 12'h5A1; wy = 12'hC3E;
        step(wx, '0, '0, 4'b0111, 1'b1, 1'b0, 1'b0);
        step(wy, '0, '0, 4'b1011, 1'b1, 1'b0, 1'b0);
        step(12'h777, '0, '0, 4'b0111, 1'b1, 1'b0, 1'b0);
        chk("R4 pair first on 1B", 32'(b1_out), 32'(wx));
        chk("R4 pair second on 2B", 32'(b2_out), 32'(wy));

        // R9: 2B loads while 1B pipe holds; then full idle
        step(12'h999, '0, '0, 4'b1011, 1'b1, 1'b0, 1'b0);
        chk("R9 b1 held during 2B load", 32'(b1_out), 32'(wx));
        chk("R3 2B loaded", 32'(b2_out), 32'h999);
        step(12'hFFF, 12'hFFF, 12'hFFF, 4'b1111, 1'b1, 1'b0, 1'b0);
        chk("R9 b1 idle", 32'(b1_out), 32'(wx));
        chk("R9 b2 idle", 32'(b2_out), 32'h999);

        // R6/R5: capture and select toward A
        step('0, 12'h1B1, 12'h2B2, 4'b1100, 1'b1, 1'b0, 1'b0);
        chk("R6 sel 1B", 32'(a_out), 32'h1B1);
        step('0, 12'hEEE, 12'hDDD, 4'b1111, 1'b0, 1'b0, 1'b0);
        chk("R6 sel 2B", 32'(a_out), 32'h2B2);
        step('0, 12'hEEE, 12'hDDD, 4'b1111, 1'b1, 1'b0, 1'b0);
        chk("R5 1B capture held", 32'(a_out), 32'h1B1);
        step('0, 12'h444, 12'h333, 4'b1110, 1'b0, 1'b1, 1'b0);
        chk("R5 2B capture loads with select", 32'(a_out), 32'h333);
        chk("R7 A released", 32'(a_drive), 0);

        // Random mix against the model
        for (int i = 0; i < 400; i++) begin
            step(W'($urandom), W'($urandom), W'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom));
            compare_all();
        end

        // Directed pairs repeated back to back (R4)
        for (int k = 0; k < 8; k++) begin
            hold1 = W'($urandom); hold2 = W'($urandom);
            step(hold1, '0, '0, 4'b0111, 1'b1, 1'b1, 1'b0);
            step(hold2, '0, '0, 4'b1011, 1'b1, 1'b1, 1'b0);
            step(W'($urandom), '0, '0, 4'b0111, 1'b1, 1'b1, 1'b0);
            chk("R4 repeated pair 1B", 32'(b1_out), 32'(hold1));
            chk("R4 repeated pair 2B", 32'(b2_out), 32'(hold2));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule